// File: doc/BRIEF.md
# Partitioned Pixel Pack Unit

This block is a one-stage SIMD datapath that carries out the pixel-formatting group of a partitioned graphics instruction set on 64-bit operands. Each issue supplies a 9-bit operation code, two 64-bit operands (`src_a`, `src_b`) and a scale field, qualified by `in_valid`. Exactly one clock later the unit presents a 64-bit result together with `out_valid`. If the code is not one of the five handled, the result is flagged as illegal.

There are three saturating packs. Each shifts every signed lane left by the scale, shifts it arithmetically right by an amount that depends on the format, and then clamps it to the target range. The other two operations involve no arithmetic: one widens bytes into 16-bit lanes and the other interleaves bytes. Pack results 32 bits wide occupy the low half of `out_data`, and the upper half is zero.

`gsr_scale` carries bits 7..3 of the graphics status register. The 16-bit pack reads only its low four bits. The other packs read all five.

The output stage is controlled by a two-state machine:
- `ST_IDLE`: no result is presented.
- `ST_EMIT`: a result is presented.

Its transitions are:
- Reset moves the machine to `ST_IDLE`.
- `ST_IDLE -> ST_EMIT` and `ST_EMIT -> ST_EMIT` occur on `in_valid`.
- `ST_EMIT -> ST_IDLE` and `ST_IDLE -> ST_IDLE` occur when `in_valid` is low.

Top module: `pixel_pack_unit`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, `out_valid` and `out_illegal` are 0 even when `in_valid` is 1.
- R2: `out_valid` is 1 exactly in the cycle after each cycle with `in_valid` = 1, and 0 otherwise; back-to-back issues give back-to-back results.
- R3: The 16-bit pack takes its scale from `gsr_scale[3:0]` and ignores `gsr_scale[4]`. The 32-bit pack and the fixed pack use all five bits.
- R4: Code 0x03B (16-bit pack): each signed 16-bit lane i of `src_b` is shifted left by the scale, shifted arithmetically right by 7, and clamped to 0..255. The result goes to byte i of `out_data`, and bits 63:32 are 0.
- R5: Code 0x03A (32-bit pack): `out_data` is `src_a` shifted left by 8, with bytes 0 and 4 replaced. Byte 0 holds the result for the low 32-bit lane of `src_b` and byte 4 the result for the high lane. Each lane is signed, shifted left by the scale, shifted right by 23 and clamped to 0..255.
- R6: Code 0x03D (fixed pack): each signed 32-bit lane w of `src_b` is shifted left by the scale, shifted right by 16 and saturated to -32768..32767. The result is placed in bits 16w+15..16w, and bits 63:32 are 0.
- R7: Code 0x04D (expand): byte i of `src_b[31:0]` is shifted left by 4 into 16-bit lane i, and the other bits of each lane are 0.
- R8: Code 0x04B (merge): byte 2i of `out_data` is byte i of `src_b` and byte 2i+1 is byte i of `src_a`, for i = 0..3.
- R9: Any other code gives `out_illegal` = 1 and `out_data` = 0 alongside `out_valid`. `out_illegal` is 0 in every cycle without `out_valid`.
- R10: For codes 0x03B and 0x03D, `out_data[63:32]` is 0.
- R11: The shifted intermediates keep every bit, so a large scale applied to a small lane saturates instead of wrapping. For example, a 32-bit lane of 0x100 with scale 31 packs to 255, and a fixed lane of 0x8000 with scale 16 packs to 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| op_code | input | 9 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| gsr_scale | input | 5 | Status register bits 7..3 (scale) |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_illegal | output | 1 | Issued code was not recognised |
| out_data | output | 64 | Result |

## Verification
The hardest case to reach is loss of intermediate precision. It only appears when a large scale meets a lane whose shifted value overflows 32 bits, and random operands rarely line up that way. Directed issues therefore place lane values such as 0x100 or 0x8000 under scales of 31 and 16, where a truncating datapath wraps to the opposite clamp. Ignoring scale bit 4 for the 16-bit pack is checked the same way: a small lane is chosen so that the two scale readings fall on opposite sides of the clamp. A long random mix, with gaps, then exercises back-to-back issue against the scoreboard.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
    localparam int OPC_W = 9;
    localparam int SCL_W = 5;

    localparam logic [OPC_W-1:0] OPC_PACK16 = 9'h03B;
    localparam logic [OPC_W-1:0] OPC_PACK32 = 9'h03A;
    localparam logic [OPC_W-1:0] OPC_FIXPK  = 9'h03D;
    localparam logic [OPC_W-1:0] OPC_EXPAND = 9'h04D;
    localparam logic [OPC_W-1:0] OPC_MERGE  = 9'h04B;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_t;
endpackage

// File: rtl/pxp_sat_lane.sv
module pxp_sat_lane #(
    parameter int     IN_W  = 16,
    parameter int     SC_W  = 4,
    parameter int     RSH   = 7,
    parameter int     OUT_W = 8,
    parameter longint LO    = 0,
    parameter longint HI    = 255
) (
    input  logic [IN_W-1:0]  din,
    input  logic [SC_W-1:0]  scale,
    output logic [OUT_W-1:0] dout
);
    // wide enough to hold the lane shifted by the largest scale
    localparam int WIDE_W = IN_W + (1 << SC_W);
    localparam logic signed [WIDE_W-1:0] LO_W = WIDE_W'(LO);
    localparam logic signed [WIDE_W-1:0] HI_W = WIDE_W'(HI);
    localparam logic [OUT_W-1:0] LO_O = OUT_W'(LO);
    localparam logic [OUT_W-1:0] HI_O = OUT_W'(HI);

    logic signed [WIDE_W-1:0] ext;
    logic signed [WIDE_W-1:0] shl;
    logic signed [WIDE_W-1:0] shr;

    always_comb begin
        ext = WIDE_W'($signed(din));
        shl = ext <<< scale;
        shr = shl >>> RSH;
        if (shr < LO_W)
            dout = LO_O;
        else if (shr > HI_W)
            dout = HI_O;
        else
            dout = shr[OUT_W-1:0];
    end
endmodule

// File: rtl/pxp_byte_fmt.sv
module pxp_byte_fmt #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W/2-1:0] a_lo,
    input  logic [DATA_W/2-1:0] b_lo,
    output logic [DATA_W-1:0]   expand_res,
    output logic [DATA_W-1:0]   merge_res
);
    localparam int NB = DATA_W / 16;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign expand_res[16*i +: 16] = {4'b0000, b_lo[8*i +: 8], 4'b0000};
        assign merge_res[16*i +: 16]  = {a_lo[8*i +: 8], b_lo[8*i +: 8]};
    end
endmodule

// File: rtl/pixel_pack_unit.sv
module pixel_pack_unit
    import pxp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OPC_W-1:0]    op_code,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [SCL_W-1:0]    gsr_scale,
    output logic                out_valid,
    output logic                out_illegal,
    output logic [DATA_W-1:0]   out_data
);
    localparam int N16  = DATA_W / 16;
    localparam int N32  = DATA_W / 32;
    localparam int HALF = DATA_W / 2;

    function automatic logic [DATA_W-1:0] low_byte_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int w = 0; w < N32; w++) m[32*w +: 8] = 8'hFF;
        return m;
    endfunction
    localparam logic [DATA_W-1:0] SLOT_MASK = low_byte_mask();

    logic [HALF-1:0]   p16_res;
    logic [HALF-1:0]   fix_res;
    logic [DATA_W-1:0] p32_ins;
    logic [DATA_W-1:0] p32_res;
    logic [DATA_W-1:0] a_shl;
    logic [DATA_W-1:0] exp_res;
    logic [DATA_W-1:0] mrg_res;

    // 16-bit lanes into bytes, 4-bit scale
    for (genvar i = 0; i < N16; i++) begin : g_p16
        pxp_sat_lane #(.IN_W(16), .SC_W(SCL_W-1), .RSH(7), .OUT_W(8),
                       .LO(0), .HI(255)) u_lane (
            .din  (src_b[16*i +: 16]),
            .scale(gsr_scale[SCL_W-2:0]),
            .dout (p16_res[8*i +: 8])
        );
    end

    // 32-bit lanes: byte pack and fixed pack, 5-bit scale
    for (genvar w = 0; w < N32; w++) begin : g_p32
        logic [7:0] byte_v;
        pxp_sat_lane #(.IN_W(32), .SC_W(SCL_W), .RSH(23), .OUT_W(8),
                       .LO(0), .HI(255)) u_byte (
            .din  (src_b[32*w +: 32]),
            .scale(gsr_scale),
            .dout (byte_v)
        );
        assign p32_ins[32*w +: 32] = {24'h000000, byte_v};

        pxp_sat_lane #(.IN_W(32), .SC_W(SCL_W), .RSH(16), .OUT_W(16),
                       .LO(-32768), .HI(32767)) u_fix (
            .din  (src_b[32*w +: 32]),
            .scale(gsr_scale),
            .dout (fix_res[16*w +: 16])
        );
    end

    assign a_shl   = src_a << 8;
    assign p32_res = (a_shl & ~SLOT_MASK) | p32_ins;

    pxp_byte_fmt #(.DATA_W(DATA_W)) u_fmt (
        .a_lo      (src_a[HALF-1:0]),
        .b_lo      (src_b[HALF-1:0]),
        .expand_res(exp_res),
        .merge_res (mrg_res)
    );

    // operation select
    logic [DATA_W-1:0] sel_data;
    logic              sel_ill;

    always_comb begin
        sel_data = '0;
        sel_ill  = 1'b0;
        unique case (op_code)
            OPC_PACK16: sel_data = {{HALF{1'b0}}, p16_res};
            OPC_PACK32: sel_data = p32_res;
            OPC_FIXPK:  sel_data = {{HALF{1'b0}}, fix_res};
            OPC_EXPAND: sel_data = exp_res;
            OPC_MERGE:  sel_data = mrg_res;
            default:    sel_ill  = 1'b1;
        endcase
    end

    // output state machine
    out_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data    <= '0;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            out_data    <= sel_data;
            out_illegal <= sel_ill;
        end else begin
            out_illegal <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/pxp_chk.sv
module pxp_chk
    import pxp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPC_W-1:0]  op_code,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [DATA_W-1:0] out_data
);
    AST_ISSUE_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_NO_ISSUE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_ILLEGAL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_valid && out_data == '0)); // R9
    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_code == OPC_PACK16 || op_code == OPC_FIXPK))
        |=> (out_data[DATA_W-1:DATA_W/2] == '0)); // R10
    AST_EXPAND_NIBBLES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == OPC_EXPAND)
        |=> (out_data[3:0] == 4'h0 && out_data[15:12] == 4'h0)); // R7
    AST_MERGE_EVEN_BYTE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == OPC_MERGE)
        |=> (out_data[7:0] == $past(src_b[7:0]) &&
             out_data[15:8] == $past(src_a[7:0]))); // R8
    AST_PACK32_SHIFTED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == OPC_PACK32)
        |=> (out_data[31:8] == $past(src_a[23:0]))); // R5
endmodule

bind pixel_pack_unit pxp_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .src_a      (src_a),
    .src_b      (src_b),
    .out_valid  (out_valid),
    .out_illegal(out_illegal),
    .out_data   (out_data)
);

// File: tb/test_pixel_pack_unit.sv
`timescale 1ns/1ps
module test_pixel_pack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  op_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [4:0]  gsr_scale = '0;
    logic        out_valid;
    logic        out_illegal;
    logic [63:0] out_data;

    always #2.5 clk = ~clk;

    pixel_pack_unit i_pixel_pack_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .gsr_scale(gsr_scale),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [64:0] q_exp[$];
    string       q_tag[$];

    task automatic chk(input bit ok, input string tag,
                       input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint clampl(longint v, longint lo, longint hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    // reference model written from the requirements: {illegal, data}
    function automatic logic [64:0] model(logic [8:0] op, logic [63:0] a,
                                          logic [63:0] b, logic [4:0] sc);
        logic [63:0] r;
        longint v;
        shortint h;
        int s32;
        r = '0;
        case (op)
            9'h03B: for (int i = 0; i < 4; i++) begin
                h = b[16*i +: 16];
                v = longint'(h) <<< sc[3:0];
                v = clampl(v >>> 7, 0, 255);
                r[8*i +: 8] = v[7:0];
            end
            9'h03A: begin
                r = (a << 8) & ~64'h000000FF_000000FF;
                for (int w = 0; w < 2; w++) begin
                    s32 = b[32*w +: 32];
                    v = longint'(s32) <<< sc;
                    v = clampl(v >>> 23, 0, 255);
                    r[32*w +: 8] = v[7:0];
                end
            end
            9'h03D: for (int w = 0; w < 2; w++) begin
                s32 = b[32*w +: 32];
                v = longint'(s32) <<< sc;
                v = clampl(v >>> 16, -32768, 32767);
                r[16*w +: 16] = v[15:0];
            end
            9'h04D: for (int i = 0; i < 4; i++) r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
            9'h04B: for (int i = 0; i < 4; i++) begin
                r[16*i +: 8]     = b[8*i +: 8];
                r[16*i + 8 +: 8] = a[8*i +: 8];
            end
            default: return {1'b1, 64'h0};
        endcase
        return {1'b0, r};
    endfunction

    task automatic issue(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [4:0] sc, input logic [64:0] exp, input string tag);
        @(negedge clk);
        op_code = op; src_a = a; src_b = b; gsr_scale = sc; in_valid = 1'b1;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    chk(1'b0, "R2 unexpected out_valid", {out_illegal, out_data}, 65'h0);
                end else begin
                    logic [64:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    chk({out_illegal, out_data} === e, t, {out_illegal, out_data}, e);
                end
            end else begin
                chk(out_illegal == 1'b0, "R9 illegal without valid", {64'h0, out_illegal}, 65'h0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [8:0] OPS[6] = '{9'h03B, 9'h03A, 9'h03D, 9'h04D, 9'h04B, 9'h03C};

    initial begin
        // R1: issue held during reset produces nothing
        rst = 1'b1; in_valid = 1'b1; op_code = 9'h03B;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0 && out_illegal == 1'b0, "R1 reset state",
            {63'h0, out_valid, out_illegal}, 65'h0);
        rst = 1'b0; in_valid = 1'b0;
        idle(2);

        // R4 hand-computed: lanes 0x40,0x7FFF,0xFF00,0x100 scale 0
        issue(9'h03B, 64'h0, 64'h0100_FF00_7FFF_0040, 5'd0, {1'b0, 64'h0000_0000_0200_FF00}, "R4 pack16 clamp");
        // R3: scale bit 4 ignored by 16-bit pack
        issue(9'h03B, 64'h0, 64'h0000_0000_0000_0080, 5'b10001, {1'b0, 64'h02}, "R3 pack16 scale bit4 ignored");
        // R3: fixed pack uses bit 4
        issue(9'h03D, 64'h0, 64'h0000_0000_0000_0001, 5'b10000, {1'b0, 64'h0001}, "R3 fixpack uses bit4");
        // R5 shift and slot insertion
        issue(9'h03A, 64'h1122_3344_5566_7788, 64'h0, 5'd0, {1'b0, 64'h2233_4400_6677_8800}, "R5 pack32 shift");
        // R11 pack32 wide intermediate
        issue(9'h03A, 64'h0, 64'h0000_0100_FFFF_FF00, 5'd31, {1'b0, 64'h0000_00FF_0000_0000}, "R11 pack32 no wrap");
        // R11/R6 fixed saturation both directions
        issue(9'h03D, 64'h0, 64'hFFFF_8000_0000_8000, 5'd16, {1'b0, 64'h0000_0000_8000_7FFF}, "R11 R6 fixpack saturate");
        issue(9'h03D, 64'h0, 64'h8000_0000_7FFF_FFFF, 5'd1, {1'b0, 64'h0000_0000_8000_7FFF}, "R6 fixpack extremes");
        // R7 expand
        issue(9'h04D, 64'h0, 64'hDEAD_BEEF_80FF_0112, 5'd7, {1'b0, 64'h0800_0FF0_0010_0120}, "R7 expand");
        // R8 merge
        issue(9'h04B, 64'hFFFF_FFFF_AABB_CCDD, 64'h5555_5555_1122_3344, 5'd0, {1'b0, 64'hAA11_BB22_CC33_DD44}, "R8 merge");
        idle(1);
        // R9 illegal codes
        issue(9'h000, 64'hFFFF, 64'hFFFF, 5'd3, {1'b1, 64'h0}, "R9 illegal 0x000");
        issue(9'h1FF, 64'hFFFF, 64'hFFFF, 5'd3, {1'b1, 64'h0}, "R9 illegal 0x1FF");
        idle(2);
        issue(9'h03C, 64'h1, 64'h1, 5'd0, {1'b1, 64'h0}, "R9 illegal 0x03C");
        // R10 narrow results with full-width negative inputs
        issue(9'h03B, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 5'd15, {1'b0, 64'h0000_0000_FFFF_FFFF}, "R10 pack16 zero ext");
        issue(9'h03D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0000_FFFF_0000, 5'd0, {1'b0, 64'h0000_0000_0001_FFFF}, "R10 fixpack zero ext");
        idle(3);

        // random mix, R2 back-to-back and gapped
        for (int n = 0; n < 80; n++) begin
            logic [8:0]  op;
            logic [63:0] a, b;
            logic [4:0]  sc;
            op = OPS[$urandom_range(0, 5)];
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            sc = 5'($urandom_range(0, 31));
            issue(op, a, b, sc, model(op, a, b, sc), "R2 random mix");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(4);
        chk(q_exp.size() == 0, "R2 all issues answered", 65'(q_exp.size()), 65'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule